// File: doc/BRIEF.md
# Spare-Steered Memory with Row and Column Redundancy

This block is a synchronous single-port memory of 8224 words by 14 bits. Repair steering is built in. The storage is 514 physical rows, and each row holds 16 multiplexed columns of the 14-bit word. The rows form two banks. The low bank has 512 rows and the high bank has 2 rows. Each bank has its own pair of spare rows. There are also two spare column groups. One serves data bits 0 to 6 and the other serves data bits 7 to 13.

On every access the address is decoded into a bank, a physical row and a column. That decode is compared with the repair settings on the input pins. When a spare row matches, the whole word is taken from that spare row or written to it. When a column spare matches, one data bit of the word is read from or written to the spare column storage. The regular array, the spare rows and the spare columns are all modelled as plain registers inside the block. A repaired location therefore keeps its own contents, separate from the cell it replaces.

The repair inputs are expected to be held static by whatever programs them. They are used combinationally on each access.

Top module: `redund_mem`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rdata` is 0.
- R2: A read (`rd_en`=1, `wr_en`=0) updates `rdata` at the clock edge that samples it, with the word most recently written to the same path. `rdata` holds its value in every cycle with no read.
- R3: Address bit 13 selects the bank (0 for the low bank, 1 for the high bank). In the low bank, bits 12..4 give the row and bits 3..0 the column. In the high bank, row 512 or 513 is picked by bit 4 alone, and bits 12..5 are ignored.
- R4: A low spare row whose enable is 1 and whose 9-bit row field equals address bits 12..4 takes every low-bank access to that row. The regular row is left untouched.
- R5: A high spare row whose enable is 1 and whose 1-bit field equals address bit 4 takes every high-bank access to that row. The regular row is left untouched.
- R6: When both spare rows of one bank match, spare 0 of that bank serves both reads and writes.
- R7: Column spare h (h=0 for bits 0..6, h=1 for bits 7..13) is active when its enable is 1 and bit 3 of its 4-bit select equals address bit 3. The steered data bit is then h*7 plus select bits 2..0, and it is stored per physical row at position address bits 2..0. The steered bit is read from and written to the spare only. The other bits use the regular path.
- R8: A column select whose bits 2..0 equal 7 steers no data bit.
- R9: A column select whose bit 3 differs from address bit 3 steers no data bit.
- R10: When `wr_en` and `rd_en` are both 1, the write is performed and `rdata` keeps its previous value.
- R11: Low spare rows never apply to high-bank addresses, and high spare rows never apply to low-bank addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 14 | Word address: bank, row, column |
| wdata | input | 14 | Write data |
| rdata | output | 14 | Registered read data |
| low_spare_en | input | 2 | Enables of the two low-bank spare rows |
| low_spare_row0 | input | 9 | Row replaced by low spare 0 |
| low_spare_row1 | input | 9 | Row replaced by low spare 1 |
| high_spare_en | input | 2 | Enables of the two high-bank spare rows |
| high_spare_row0 | input | 1 | Row (512/513) replaced by high spare 0 |
| high_spare_row1 | input | 1 | Row (512/513) replaced by high spare 1 |
| col_spare_en | input | 2 | Enables of the two column spare groups |
| col_spare_sel0 | input | 4 | Column group select for bits 0..6 |
| col_spare_sel1 | input | 4 | Column group select for bits 7..13 |

## Verification
Directed patterns write through one repair setting and read back through another, so that a spare location and the regular cell it hides are told apart. These cover single and doubled spare rows, high-bank aliasing on bits 12..5, a low-bank spare field that equals the low row bits of a high-bank address, and column selects with bits 2..0 equal to 7 or with a mismatched bit 3. Constrained random traffic follows, over a small pool of rows. The repair settings are changed every few dozen operations, so that writes and reads land under differing steering. A bench model with separate regular, spare-row and spare-column stores predicts every bit, and only bits whose storage has been written are compared. A same-cycle read and write checks that the write goes through and `rdata` holds.

// File: rtl/redund_mem_pkg.sv
package redund_mem_pkg;
    parameter int HALF_W   = 7;
    parameter int N_HALF   = 2;
    parameter int DATA_W   = HALF_W * N_HALF;
    parameter int MUX_N    = 16;
    parameter int LOW_ROWS = 512;
    parameter int HIGH_ROWS = 2;
    parameter int GRP_N    = MUX_N / 2;
    parameter int N_SPARE  = 4;

    localparam int COL_AW  = $clog2(MUX_N);
    localparam int ROW_AW  = $clog2(LOW_ROWS);
    localparam int ADDR_W  = 1 + ROW_AW + COL_AW;
    localparam int PROWS   = LOW_ROWS + HIGH_ROWS;
    localparam int PROW_W  = $clog2(PROWS);
    localparam int GRP_AW  = $clog2(GRP_N);
    localparam int SIDX_W  = $clog2(N_SPARE);
    localparam int SEL_W   = GRP_AW + 1;
    localparam int BANK_B  = ADDR_W - 1;

    typedef struct packed {
        logic              high;
        logic [PROW_W-1:0] prow;
        logic [COL_AW-1:0] col;
    } acc_t;

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.high = a[BANK_B];
        r.col  = a[COL_AW-1:0];
        if (a[BANK_B])
            r.prow = PROW_W'(LOW_ROWS) + PROW_W'(a[COL_AW]);
        else
            r.prow = PROW_W'(a[COL_AW +: ROW_AW]);
        return r;
    endfunction
endpackage

// File: rtl/redund_mem_decode.sv
module redund_mem_decode
    import redund_mem_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    always_comb acc = decode_addr(addr);
endmodule

// File: rtl/redund_mem_row_match.sv
module redund_mem_row_match #(
    parameter int AW = 9
) (
    input  logic          bank_sel,
    input  logic [1:0]    en,
    input  logic [AW-1:0] row0,
    input  logic [AW-1:0] row1,
    input  logic [AW-1:0] key,
    output logic [1:0]    hit
);
    logic m0, m1;
    always_comb begin
        m0  = bank_sel & en[0] & (row0 == key);
        m1  = bank_sel & en[1] & (row1 == key);
        hit = {m1 & ~m0, m0};
    end
endmodule

// File: rtl/redund_mem_col_steer.sv
module redund_mem_col_steer
    import redund_mem_pkg::*;
(
    input  logic [N_HALF-1:0]            en,
    input  logic [N_HALF-1:0][SEL_W-1:0] sel,
    input  logic                         col_hi,
    output logic [DATA_W-1:0]            mask
);
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic [GRP_AW-1:0] bitsel;
        logic              act;
        always_comb begin
            bitsel = sel[h][GRP_AW-1:0];
            act    = en[h] & (sel[h][GRP_AW] == col_hi) & (bitsel != GRP_AW'(GRP_N - 1));
        end
        for (genvar i = 0; i < HALF_W; i++) begin : g_bit
            assign mask[h*HALF_W + i] = act & (bitsel == GRP_AW'(i));
        end
    end
endmodule

// File: rtl/redund_mem.sv
module redund_mem
    import redund_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [13:0]       addr,
    input  logic [13:0]       wdata,
    output logic [13:0]       rdata,
    input  logic [1:0]        low_spare_en,
    input  logic [8:0]        low_spare_row0,
    input  logic [8:0]        low_spare_row1,
    input  logic [1:0]        high_spare_en,
    input  logic              high_spare_row0,
    input  logic              high_spare_row1,
    input  logic [1:0]        col_spare_en,
    input  logic [3:0]        col_spare_sel0,
    input  logic [3:0]        col_spare_sel1
);
    acc_t                acc;
    logic                acc_high;
    logic [N_SPARE-1:0]  spare_hit;
    logic                spare_any;
    logic [SIDX_W-1:0]   sidx;
    logic [DATA_W-1:0]   col_mask;
    logic [N_HALF-1:0]   col_bit;
    logic [DATA_W-1:0]   base_word;
    logic [DATA_W-1:0]   rd_word;

    logic [MUX_N-1:0][DATA_W-1:0] main_q  [PROWS];
    logic [MUX_N-1:0][DATA_W-1:0] spare_q [N_SPARE];

    redund_mem_decode u_dec (.addr(addr), .acc(acc));
    assign acc_high = acc.high;

    redund_mem_row_match #(.AW(ROW_AW)) u_low (
        .bank_sel(~acc.high), .en(low_spare_en),
        .row0(low_spare_row0), .row1(low_spare_row1),
        .key(acc.prow[ROW_AW-1:0]), .hit(spare_hit[1:0])
    );

    redund_mem_row_match #(.AW(1)) u_high (
        .bank_sel(acc.high), .en(high_spare_en),
        .row0(high_spare_row0), .row1(high_spare_row1),
        .key(acc.prow[0]), .hit(spare_hit[3:2])
    );

    redund_mem_col_steer u_col (
        .en(col_spare_en), .sel({col_spare_sel1, col_spare_sel0}),
        .col_hi(acc.col[GRP_AW]), .mask(col_mask)
    );

    always_comb begin
        spare_any = |spare_hit;
        sidx = '0;
        for (int i = 0; i < N_SPARE; i++)
            if (spare_hit[i]) sidx = SIDX_W'(i);
    end

    // Column spare storage, one bit per group position per physical row.
    for (genvar h = 0; h < N_HALF; h++) begin : g_cs
        localparam logic [DATA_W-1:0] HMASK = DATA_W'(((1 << HALF_W) - 1) << (h * HALF_W));
        logic [GRP_N-1:0] store_q [PROWS];
        always_ff @(posedge clk) begin
            if (wr_en && |(col_mask & HMASK))
                store_q[acc.prow][acc.col[GRP_AW-1:0]] <= |(wdata & col_mask & HMASK);
        end
        assign col_bit[h] = store_q[acc.prow][acc.col[GRP_AW-1:0]];
    end

    always_comb begin
        base_word = spare_any ? spare_q[sidx][acc.col] : main_q[acc.prow][acc.col];
        rd_word   = base_word;
        for (int b = 0; b < DATA_W; b++)
            if (col_mask[b]) rd_word[b] = (b >= HALF_W) ? col_bit[1] : col_bit[0];
    end

    // Row storage: bits steered to a column spare keep their old value.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (spare_any)
                spare_q[sidx][acc.col] <= (spare_q[sidx][acc.col] & col_mask) | (wdata & ~col_mask);
            else
                main_q[acc.prow][acc.col] <= (main_q[acc.prow][acc.col] & col_mask) | (wdata & ~col_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en && !wr_en)
            rdata <= rd_word;
    end
endmodule

// File: rtl/redund_mem_chk.sv
module redund_mem_chk
    import redund_mem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [13:0]       rdata,
    input logic [N_SPARE-1:0] spare_hit,
    input logic [DATA_W-1:0] col_mask,
    input logic              acc_high
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: read register is clear in the cycle after reset
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1)
            p_reset_clear_r1: assert (rdata == '0);
    end

    // R2 / R10: rdata only moves on a read without a write
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || wr_en) |=> $stable(rdata));

    // R6: at most one spare row serves an access
    p_one_spare_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spare_hit));

    // R11: spare pools do not cross banks
    p_low_pool_r11: assert property (@(posedge clk) disable iff (rst)
        acc_high |-> (spare_hit[1:0] == 2'b00));
    p_high_pool_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_high |-> (spare_hit[3:2] == 2'b00));

    // R7: at most one steered bit per half
    p_one_bit_low_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(col_mask[HALF_W-1:0]) <= 1);
    p_one_bit_high_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(col_mask[DATA_W-1:HALF_W]) <= 1);
endmodule

bind redund_mem redund_mem_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata),
    .spare_hit(spare_hit), .col_mask(col_mask), .acc_high(acc_high)
);

// File: tb/redund_mem_test.sv
module redund_mem_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [13:0] addr, wdata;
    logic [13:0] rdata;
    logic [1:0]  low_en, high_en, col_en;
    logic [8:0]  low_r0, low_r1;
    logic        high_r0, high_r1;
    logic [3:0]  col_s0, col_s1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mdl [int];

    always #10 clk = ~clk;

    redund_mem uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .low_spare_en(low_en), .low_spare_row0(low_r0), .low_spare_row1(low_r1),
        .high_spare_en(high_en), .high_spare_row0(high_r0), .high_spare_row1(high_r1),
        .col_spare_en(col_en), .col_spare_sel0(col_s0), .col_spare_sel1(col_s1)
    );

    function automatic int m_prow(logic [13:0] a);
        return a[13] ? 512 + int'(a[4]) : int'(a[12:4]);
    endfunction

    function automatic int m_spare(logic [13:0] a);
        if (!a[13]) begin
            if (low_en[0] && low_r0 == a[12:4]) return 0;
            if (low_en[1] && low_r1 == a[12:4]) return 1;
        end else begin
            if (high_en[0] && high_r0 == a[4]) return 2;
            if (high_en[1] && high_r1 == a[4]) return 3;
        end
        return -1;
    endfunction

    function automatic int m_colbit(int h, logic [13:0] a);
        logic [3:0] f = (h == 1) ? col_s1 : col_s0;
        if (col_en[h] && f[3] == a[3] && f[2:0] != 3'd7) return h * 7 + int'(f[2:0]);
        return -1;
    endfunction

    function automatic int m_key(logic [13:0] a, int b);
        int h = b / 7;
        int s = m_spare(a);
        if (m_colbit(h, a) == b) return 400000 + (h * 514 + m_prow(a)) * 8 + int'(a[2:0]);
        if (s >= 0) return 200000 + (s * 16 + int'(a[3:0])) * 14 + b;
        return (m_prow(a) * 16 + int'(a[3:0])) * 14 + b;
    endfunction

    task automatic chk(string tag, logic [13:0] act, logic [13:0] exp, logic [13:0] known);
        checks++;
        if ((act & known) !== (exp & known)) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, known);
        end
    endtask

    task automatic do_write(logic [13:0] a, logic [13:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        for (int b = 0; b < 14; b++) mdl[m_key(a, b)] = d[b];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [13:0] a, string tag);
        logic [13:0] exp = '0, known = '0;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        for (int b = 0; b < 14; b++) begin
            int k = m_key(a, b);
            if (mdl.exists(k)) begin exp[b] = mdl[k]; known[b] = 1'b1; end
        end
        @(negedge clk);
        rd_en = 1'b0;
        if (known != '0) chk(tag, rdata, exp, known);
    endtask

    task automatic clear_cfg();
        low_en = 0; high_en = 0; col_en = 0;
        low_r0 = 0; low_r1 = 0; high_r0 = 0; high_r1 = 0; col_s0 = 0; col_s1 = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [13:0] held;
        logic [13:0] pool_low [4];
        void'($urandom(32'd20240311));
        pool_low = '{14'd3, 14'd200, 14'd511, 14'd77};
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        clear_cfg();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset", rdata, 14'h0000, 14'h3FFF);

        // R2: plain write/read
        do_write(14'h0015, 14'h1234);
        do_write(14'h1FFF, 14'h2ACE);
        do_read(14'h0015, "R2 plain");
        do_read(14'h1FFF, "R2 plain last");
        held = rdata;
        @(negedge clk); @(negedge clk);
        chk("R2 hold", rdata, held, 14'h3FFF);

        // R3: high-bank aliasing on bits 12..5
        do_write(14'h2013, 14'h0F0F);
        do_write(14'h2003, 14'h3333);
        do_read(14'h3FF3, "R3 alias");
        chk("R3 alias value", rdata, 14'h0F0F, 14'h3FFF);

        // R4: low spare row
        do_write(14'h0052, 14'h1111);
        low_en = 2'b01; low_r0 = 9'd5;
        do_write(14'h0052, 14'h2222);
        do_read(14'h0052, "R4 spare");
        low_en = 2'b00;
        do_read(14'h0052, "R4 regular kept");
        chk("R4 regular value", rdata, 14'h1111, 14'h3FFF);

        // R6: doubled low spare, spare 0 wins
        low_en = 2'b10; low_r1 = 9'd5;
        do_write(14'h0052, 14'h0AAA);
        low_en = 2'b11; low_r0 = 9'd5;
        do_write(14'h0052, 14'h1555);
        do_read(14'h0052, "R6 both");
        low_en = 2'b10;
        do_read(14'h0052, "R6 spare1 untouched");
        chk("R6 spare1 value", rdata, 14'h0AAA, 14'h3FFF);
        clear_cfg();

        // R5: high spare row
        do_write(14'h2010, 14'h0123);
        high_en = 2'b01; high_r0 = 1'b1;
        do_write(14'h2010, 14'h0456);
        do_read(14'h2000, "R5 other row");
        do_read(14'h2010, "R5 spare");
        high_en = 2'b00;
        do_read(14'h2010, "R5 regular kept");
        chk("R5 regular value", rdata, 14'h0123, 14'h3FFF);

        // R11: low spare field equal to low bits of a high address
        low_en = 2'b01; low_r0 = 9'd1;
        do_write(14'h2010, 14'h3C3C);
        low_en = 2'b00;
        do_read(14'h2010, "R11 no cross");
        chk("R11 value", rdata, 14'h3C3C, 14'h3FFF);

        // R7: column spares (low half bit 2, high half bit 10)
        do_write(14'h009A, 14'h3FFF);
        col_en = 2'b11; col_s0 = 4'b1010; col_s1 = 4'b1011;
        do_write(14'h009A, 14'h0000);
        do_read(14'h009A, "R7 steered");
        chk("R7 steered value", rdata, 14'h0000, 14'h3FFF);
        col_en = 2'b00;
        do_read(14'h009A, "R7 regular bits kept");
        chk("R7 regular value", rdata, 14'h0404, 14'h3FFF);
        clear_cfg();

        // R9: bit 3 mismatch steers nothing
        do_write(14'h009A, 14'h3FFF);
        col_en = 2'b01; col_s0 = 4'b0010;
        do_write(14'h009A, 14'h0000);
        col_en = 2'b00;
        do_read(14'h009A, "R9 mismatch");
        chk("R9 value", rdata, 14'h0000, 14'h3FFF);

        // R8: select 7 steers nothing
        do_write(14'h009A, 14'h3FFF);
        col_en = 2'b11; col_s0 = 4'b1111; col_s1 = 4'b1111;
        do_write(14'h009A, 14'h0000);
        col_en = 2'b00;
        do_read(14'h009A, "R8 select seven");
        chk("R8 value", rdata, 14'h0000, 14'h3FFF);
        clear_cfg();

        // R10: simultaneous read and write
        do_read(14'h0015, "R10 setup");
        held = rdata;
        @(negedge clk);
        wr_en = 1; rd_en = 1; addr = 14'h0016; wdata = 14'h2BAD;
        for (int b = 0; b < 14; b++) mdl[m_key(14'h0016, b)] = wdata[b];
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk("R10 hold", rdata, held, 14'h3FFF);
        do_read(14'h0016, "R10 written");

        // Random traffic: R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            logic [13:0] a;
            if (n % 40 == 0) begin
                low_en  = 2'($urandom);
                low_r0  = 9'(pool_low[$urandom % 4]);
                low_r1  = 9'(pool_low[$urandom % 4]);
                high_en = 2'($urandom);
                high_r0 = 1'($urandom);
                high_r1 = 1'($urandom);
                col_en  = 2'($urandom);
                col_s0  = 4'($urandom);
                col_s1  = 4'($urandom);
            end
            if ($urandom % 4 == 0)
                a = {1'b1, 8'($urandom), 1'($urandom), 4'($urandom)};
            else
                a = {1'b0, pool_low[$urandom % 4][8:0], 4'($urandom)};
            if ($urandom % 2 == 0) do_write(a, 14'($urandom));
            else do_read(a, "R2/R4/R7 random");
        end
        finish_run();
    end
endmodule